// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Read Lookup

This block is the read path of a first-level data cache. The cache set is chosen from address bits inside the page offset. Those bits are the same in the virtual and the physical address, so the set can be picked while an external translation unit is still resolving the page. The stored tags are physical page numbers, and they are compared only after the translation response has arrived. On a hit, the selected 32-bit word leaves through a fixed-latency pipeline. On a miss, the block raises one line-fill request carrying the physical line address and waits for the whole line. It writes the line into a way, replays the lookup and returns the word.

A load is accepted with `req_valid` while `req_ready` is high. The translation response (`xl_valid`, `xl_hit`, `xl_ppn`) is expected from the cycle after acceptance onward. The controller has five states:
- `S_IDLE` accepts a request.
- `S_XLATE` waits for a usable translation and compares the tags.
- `S_FILL_REQ` issues the line request.
- `S_FILL_WAIT` waits for `refill_valid`.
- `S_REPLAY` repeats the compare against the new contents.

The transitions are:
- IDLE→XLATE on acceptance.
- XLATE→XLATE while no usable translation is present.
- XLATE→IDLE on a hit.
- XLATE→FILL_REQ on a miss.
- FILL_REQ→FILL_WAIT unconditionally.
- FILL_WAIT→REPLAY when the refill arrives.
- REPLAY→IDLE.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `fill_req` are 0. Every way is invalid, so the first load to any line misses.
- R2: The set index is `req_vaddr[11:6]`, giving 64 sets. The returned word is word `req_vaddr[5:2]` of the line, at line bits [32w+31:32w]. The tag is physical: a load with a different virtual page but the same index and page number hits, and the same page number with a different index misses.
- R3: A hit needs a valid way whose tag equals the translated page number. If the translation is supplied in cycle 1 (acceptance cycle = 0), `resp_valid`=1 and `resp_hit`=1 appear in cycle HIT_LAT (default 4).
- R4: While the lookup sees `xl_valid`=0 or `xl_hit`=0, it stalls. No fill request is issued and no response is produced, and the result is delayed by exactly the number of stalled cycles.
- R5: A miss raises `fill_req` for exactly one cycle, the cycle after the compare, with `fill_line_addr` = {page number, set index}.
- R6: The refilled line goes into the lowest-numbered invalid way of its set. The replayed response carries `resp_hit`=0 and the word from the refilled line, and appears HIT_LAT cycles after the cycle in which `refill_valid` is high.
- R7: When every way of a set is valid, the victim is chosen by a per-set round-robin pointer. The pointer starts at way 0, advances by one on each such replacement and wraps after the last way.
- R8: `req_ready` is 0 from the cycle after a missing compare through the replay cycle, and 1 again in the following cycle. Only one miss is outstanding at a time.
- R9: With WAYS=12, a set holds twelve distinct lines, and the thirteenth evicts the first one filled.
- R10: With PAGE_BYTES=16384, the index is `req_vaddr[13:6]` (256 sets), the page number is the physical address above bit 13, and associativity is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Load can be accepted this cycle |
| req_vaddr | input | VA_W | Virtual byte address of the load |
| xl_valid | input | 1 | Translation response present |
| xl_hit | input | 1 | Translation response holds a usable page number |
| xl_ppn | input | PA_W-log2(PAGE_BYTES) | Physical page number |
| fill_req | output | 1 | One-cycle line request to the next level |
| fill_line_addr | output | PA_W-log2(LINE_BYTES) | Physical line address of the request |
| refill_valid | input | 1 | Refill line present |
| refill_line | input | LINE_BYTES*8 | Whole refill line, word w in bits [32w+31:32w] |
| resp_valid | output | 1 | Load result valid |
| resp_hit | output | 1 | 1 if the load hit on its first compare |
| resp_word | output | WORD_BYTES*8 | Loaded word |

## Verification
The bench targets aliasing: two virtual pages that share an index and a physical page must hit the same line. A design that tagged with virtual bits would miss there. A design that indexed with translated bits would miss on the index test. Stalls mixing absent and unusable translations are checked for exact delay; a design that compared too early would emit a fill or response with a garbage tag. Set-filling sequences check the invalid-first order and the round-robin wrap, where a wrong pointer evicts a line that should still hit. A second configuration with twelve ways and 16 KB pages checks that bit 12 selects a different set rather than forming part of the tag.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XLATE,
        S_FILL_REQ,
        S_FILL_WAIT,
        S_REPLAY
    } vipt_state_e;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int IDX_W = 6,
    parameter int WAY_W = 3,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAY_W-1:0] rr_q    [SETS];
    logic [WAYS-1:0]  match_vec;

    // One comparator per way of the selected set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == cmp_tag);
    end

    assign hit = |match_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Lowest invalid way first, otherwise the set's round-robin pointer
    always_comb begin
        victim_way = rr_q[rd_idx];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[rd_idx][w]) victim_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
            if (&valid_q[wr_idx]) begin
                rr_q[wr_idx] <= (rr_q[wr_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[wr_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    // R3: a physical tag lives in at most one way of a set
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec))
        else $error("a_r3_single_match");

    // R6: a set with free ways is refilled into a free way
    a_r6_fill_free_way: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(&valid_q[wr_idx])) |-> !valid_q[wr_idx][wr_way])
        else $error("a_r6_fill_free_way");

    // R7: a full set is refilled at its round-robin pointer
    a_r7_fill_rr_way: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&valid_q[wr_idx])) |-> (wr_way == rr_q[wr_idx]))
        else $error("a_r7_fill_rr_way");

    // R7: the pointer never leaves the way range
    a_r7_rr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (int'(rr_q[$past(wr_idx)]) < WAYS))
        else $error("a_r7_rr_in_range");

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 8,
    parameter int IDX_W  = 6,
    parameter int WAY_W  = 3,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WSEL_W-1:0] rd_sel,
    output logic [WORD_W-1:0] rd_word
);

    localparam int ENTRIES = SETS * WAYS;
    localparam int ENT_W   = $clog2(ENTRIES);

    logic [LINE_W-1:0] lines_q [ENTRIES];
    logic [LINE_W-1:0] rd_line;

    function automatic logic [ENT_W-1:0] slot(input logic [IDX_W-1:0] idx,
                                              input logic [WAY_W-1:0] way);
        return ENT_W'(idx) * ENT_W'(WAYS) + ENT_W'(way);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) lines_q[slot(wr_idx, wr_way)] <= wr_line;
    end

    assign rd_line = lines_q[slot(rd_idx, rd_way)];
    assign rd_word = rd_line[int'(rd_sel) * WORD_W +: WORD_W];

endmodule

// File: rtl/vipt_resp_pipe.sv
module vipt_resp_pipe #(
    parameter int DEPTH = 3,
    parameter int W     = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic [DEPTH-1:0] v_q;
    logic [W-1:0]     d_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) v_q[0] <= 1'b0;
                else        v_q[0] <= in_valid;
                d_q[0] <= in_data;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) v_q[i] <= 1'b0;
                else        v_q[i] <= v_q[i-1];
                d_q[i] <= d_q[i-1];
            end
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_data  = d_q[DEPTH-1];

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64,
    parameter int WAYS       = 8,
    parameter int WORD_BYTES = 4,
    parameter int HIT_LAT    = 4   // at least 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [VA_W-1:0]                       req_vaddr,
    input  logic                                  xl_valid,
    input  logic                                  xl_hit,
    input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]    xl_ppn,
    output logic                                  fill_req,
    output logic [PA_W-$clog2(LINE_BYTES)-1:0]    fill_line_addr,
    input  logic                                  refill_valid,
    input  logic [LINE_BYTES*8-1:0]               refill_line,
    output logic                                  resp_valid,
    output logic                                  resp_hit,
    output logic [WORD_BYTES*8-1:0]               resp_word
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int LOFF_W = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(WORD_BYTES);
    localparam int IDX_W  = OFF_W - LOFF_W;
    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = PA_W - OFF_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int WSEL_W = LOFF_W - BSEL_W;
    localparam int PIPE_D = HIT_LAT - 1;

    vipt_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q;
    logic [WSEL_W-1:0] wsel_q;
    logic [TAG_W-1:0]  ppn_q;
    logic              xl_ok;
    logic [TAG_W-1:0]  cmp_tag;
    logic              tag_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim_way;
    logic              fill_wr;
    logic [WORD_W-1:0] rd_word;
    logic              pipe_in_valid;
    logic              pipe_in_hit;
    logic              unused_va;

    assign unused_va = ^{req_vaddr[VA_W-1:OFF_W], req_vaddr[BSEL_W-1:0]};

    assign xl_ok   = xl_valid && xl_hit;
    assign cmp_tag = (state_q == S_XLATE) ? xl_ppn : ppn_q;
    assign fill_wr = (state_q == S_FILL_WAIT) && refill_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid)   state_d = S_XLATE;
            S_XLATE:     if (xl_ok)       state_d = tag_hit ? S_IDLE : S_FILL_REQ;
            S_FILL_REQ:                   state_d = S_FILL_WAIT;
            S_FILL_WAIT: if (refill_valid) state_d = S_REPLAY;
            S_REPLAY:                     state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        req_ready     = 1'b0;
        fill_req      = 1'b0;
        pipe_in_valid = 1'b0;
        pipe_in_hit   = 1'b0;
        unique case (state_q)
            S_IDLE:      req_ready = 1'b1;
            S_XLATE: begin
                pipe_in_valid = xl_ok && tag_hit;
                pipe_in_hit   = 1'b1;
            end
            S_FILL_REQ:  fill_req = 1'b1;
            S_FILL_WAIT: ;
            S_REPLAY:    pipe_in_valid = 1'b1;
            default:     ;
        endcase
    end

    assign fill_line_addr = {ppn_q, idx_q};

    // Request and translation capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wsel_q <= '0;
            ppn_q  <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                idx_q  <= req_vaddr[OFF_W-1:LOFF_W];
                wsel_q <= req_vaddr[LOFF_W-1:BSEL_W];
            end
            if (state_q == S_XLATE && xl_ok) ppn_q <= xl_ppn;
        end
    end

    vipt_tag_store #(
        .SETS (SETS),
        .WAYS (WAYS),
        .IDX_W(IDX_W),
        .WAY_W(WAY_W),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx_q),
        .cmp_tag   (cmp_tag),
        .hit       (tag_hit),
        .hit_way   (hit_way),
        .victim_way(victim_way),
        .wr_en     (fill_wr),
        .wr_idx    (idx_q),
        .wr_way    (victim_way),
        .wr_tag    (ppn_q)
    );

    vipt_line_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W),
        .LINE_W(LINE_W),
        .WORD_W(WORD_W),
        .WSEL_W(WSEL_W)
    ) u_lines (
        .clk    (clk),
        .wr_en  (fill_wr),
        .wr_idx (idx_q),
        .wr_way (victim_way),
        .wr_line(refill_line),
        .rd_idx (idx_q),
        .rd_way (hit_way),
        .rd_sel (wsel_q),
        .rd_word(rd_word)
    );

    vipt_resp_pipe #(
        .DEPTH(PIPE_D),
        .W    (WORD_W + 1)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (pipe_in_valid),
        .in_data  ({pipe_in_hit, rd_word}),
        .out_valid(resp_valid),
        .out_data ({resp_hit, resp_word})
    );

    // R5: the line request is a single-cycle pulse
    a_r5_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !fill_req)
        else $error("a_r5_single_fill");

    // R5: a line request follows only a usable translation that missed
    a_r5_fill_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(state_q == S_XLATE && xl_ok && !tag_hit))
        else $error("a_r5_fill_after_miss");

    // R4: a stalled lookup requests nothing and keeps its page number
    a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XLATE && !xl_ok) |=> (!fill_req && $stable(ppn_q)))
        else $error("a_r4_stall_quiet");

    // R6: the replay after a refill always finds the line
    a_r6_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REPLAY) |-> tag_hit)
        else $error("a_r6_replay_hits");

    // R8: no new request is captured while a lookup is in progress
    a_r8_busy_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(idx_q) && $stable(wsel_q)))
        else $error("a_r8_busy_holds_req");

endmodule

// File: tb/vipt_l1_lookup_test.sv
module vipt_l1_lookup_test;

    localparam int CLK_PERIOD = 10;
    localparam int HIT_LAT    = 4;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         xl_valid = 1'b0;
    logic         xl_hit = 1'b0;
    logic [19:0]  xl_ppn = '0;
    logic         refill_valid = 1'b0;
    logic [511:0] refill_line = '0;

    logic         a_ready, a_fill, a_rvalid, a_rhit;
    logic [25:0]  a_faddr;
    logic [31:0]  a_word;
    logic         b_ready, b_fill, b_rvalid, b_rhit;
    logic [25:0]  b_faddr;
    logic [31:0]  b_word;

    logic         m_ready, m_fill, m_rvalid, m_rhit;
    logic [25:0]  m_faddr;
    logic [31:0]  m_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vipt_l1_lookup uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && !sel), .req_ready(a_ready), .req_vaddr(req_vaddr),
        .xl_valid(xl_valid && !sel), .xl_hit(xl_hit), .xl_ppn(xl_ppn),
        .fill_req(a_fill), .fill_line_addr(a_faddr),
        .refill_valid(refill_valid && !sel), .refill_line(refill_line),
        .resp_valid(a_rvalid), .resp_hit(a_rhit), .resp_word(a_word)
    );

    vipt_l1_lookup #(.WAYS(12), .PAGE_BYTES(16384)) uut2 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && sel), .req_ready(b_ready), .req_vaddr(req_vaddr),
        .xl_valid(xl_valid && sel), .xl_hit(xl_hit), .xl_ppn(xl_ppn[17:0]),
        .fill_req(b_fill), .fill_line_addr(b_faddr),
        .refill_valid(refill_valid && sel), .refill_line(refill_line),
        .resp_valid(b_rvalid), .resp_hit(b_rhit), .resp_word(b_word)
    );

    assign m_ready  = sel ? b_ready  : a_ready;
    assign m_fill   = sel ? b_fill   : a_fill;
    assign m_faddr  = sel ? b_faddr  : a_faddr;
    assign m_rvalid = sel ? b_rvalid : a_rvalid;
    assign m_rhit   = sel ? b_rhit   : a_rhit;
    assign m_word   = sel ? b_word   : a_word;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [25:0] la, input int w);
        return {la, 2'b10, 4'(w)};
    endfunction

    function automatic logic [511:0] make_line(input logic [25:0] la);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = word_of(la, w);
        return l;
    endfunction

    // One load: xd stall cycles before translation, rd cycles before refill
    task automatic do_load(input logic [31:0] va, input logic [19:0] ppn,
                           input int xd, input int rd, input bit exp_hit,
                           input string tag);
        logic [25:0] la;
        int fill_k, refill_k, resp_k, fills, waits;
        bit stray;
        la = sel ? {ppn[17:0], va[13:6]} : {ppn, va[11:6]};
        fill_k   = 2 + xd;
        refill_k = 3 + xd + rd;
        resp_k   = exp_hit ? (HIT_LAT + xd) : (refill_k + HIT_LAT);
        fills = 0;
        stray = 1'b0;
        waits = 0;
        while (!m_ready && waits < 50) begin
            @(negedge clk);
            waits++;
        end
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= resp_k; k++) begin
            // sample cycle k
            if (m_fill) begin
                fills++;
                chk(!exp_hit && k == fill_k, tag, "fill_req cycle", 64'(k), 64'(fill_k));
                chk(m_faddr == la, tag, "fill_line_addr", 64'(m_faddr), 64'(la));
            end
            if (k == resp_k) begin
                chk(m_rvalid, tag, "resp_valid", 64'(m_rvalid), 64'd1);
                chk(m_rhit == exp_hit, tag, "resp_hit", 64'(m_rhit), 64'(exp_hit));
                chk(m_word == word_of(la, int'(va[5:2])), tag, "resp_word",
                    64'(m_word), 64'(word_of(la, int'(va[5:2]))));
            end else if (m_rvalid) begin
                stray = 1'b1;
            end
            if (!exp_hit && k >= fill_k && k <= refill_k + 1)
                chk(!m_ready, "R8", "req_ready busy", 64'(m_ready), 64'd0);
            if (!exp_hit && k == refill_k + 2)
                chk(m_ready, "R8", "req_ready after replay", 64'(m_ready), 64'd1);
            // drive cycle k
            if (k <= xd) begin
                xl_valid = (k % 2 == 0);
                xl_hit   = 1'b0;
                xl_ppn   = ~ppn;
            end else if (k == xd + 1) begin
                xl_valid = 1'b1;
                xl_hit   = 1'b1;
                xl_ppn   = ppn;
            end else begin
                xl_valid = 1'b0;
                xl_hit   = 1'b0;
            end
            refill_valid = !exp_hit && (k == refill_k);
            refill_line  = make_line(la);
            @(negedge clk);
        end
        xl_valid = 1'b0;
        refill_valid = 1'b0;
        chk(!stray, tag, "no early response (R4)", 64'(stray), 64'd0);
        chk(fills == (exp_hit ? 0 : 1), "R5", "fill_req count", 64'(fills), 64'(exp_hit ? 0 : 1));
    endtask

    task automatic t_reset();
        chk(m_ready, "R1", "req_ready", 64'(m_ready), 64'd1);
        chk(!m_rvalid, "R1", "resp_valid", 64'(m_rvalid), 64'd0);
        chk(!m_fill, "R1", "fill_req", 64'(m_fill), 64'd0);
    endtask

    task automatic t_cold_and_hit();
        do_load(32'h0000_1044, 20'h12345, 0, 0, 1'b0, "R1");
        do_load(32'h0000_1078, 20'h12345, 0, 0, 1'b1, "R3");
        do_load(32'h0000_1040, 20'h54321, 0, 1, 1'b0, "R3");
        do_load(32'h0000_1040, 20'h12345, 0, 0, 1'b1, "R6");
        do_load(32'h0000_107C, 20'h54321, 0, 0, 1'b1, "R6");
    endtask

    task automatic t_physical_tag();
        do_load(32'h7777_3048, 20'h12345, 0, 0, 1'b1, "R2");
        do_load(32'h0000_1080, 20'h12345, 0, 0, 1'b0, "R2");
        do_load(32'hABCD_E084, 20'h12345, 0, 0, 1'b1, "R2");
    endtask

    task automatic t_stall();
        do_load(32'h0000_1050, 20'h12345, 3, 0, 1'b1, "R4");
        do_load(32'h0000_20C0, 20'h0ABCD, 2, 3, 1'b0, "R4");
        do_load(32'h0000_20C8, 20'h0ABCD, 1, 0, 1'b1, "R4");
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < 8; i++) do_load(32'h0000_0140, 20'h00100 + 20'(i), 0, 0, 1'b0, "R6");
        for (int i = 0; i < 8; i++) do_load(32'h0000_0144, 20'h00100 + 20'(i), 0, 0, 1'b1, "R7");
        do_load(32'h0000_0140, 20'h00108, 0, 0, 1'b0, "R7");   // evicts way 0
        do_load(32'h0000_0148, 20'h00101, 0, 0, 1'b1, "R7");
        do_load(32'h0000_0140, 20'h00100, 0, 0, 1'b0, "R7");   // evicts way 1
        do_load(32'h0000_0140, 20'h00101, 0, 0, 1'b0, "R7");   // evicts way 2
        do_load(32'h0000_014C, 20'h00103, 0, 0, 1'b1, "R7");
        do_load(32'h0000_0140, 20'h00108, 0, 0, 1'b1, "R7");
    endtask

    task automatic t_wide_assoc();
        sel = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 12; i++) do_load(32'h0000_00C0, 20'h00200 + 20'(i), 0, 0, 1'b0, "R9");
        for (int i = 0; i < 12; i++) do_load(32'h0000_00C4, 20'h00200 + 20'(i), 0, 0, 1'b1, "R9");
        do_load(32'h0000_00C0, 20'h0020C, 0, 0, 1'b0, "R9");
        do_load(32'h0000_00C0, 20'h00200, 0, 0, 1'b0, "R9");
        do_load(32'h0000_00D0, 20'h0020B, 0, 0, 1'b1, "R9");
    endtask

    task automatic t_big_page();
        do_load(32'h0000_0040, 20'h00155, 0, 0, 1'b0, "R10");
        do_load(32'h0000_1040, 20'h00155, 0, 0, 1'b0, "R10");
        do_load(32'h0000_0044, 20'h00155, 0, 0, 1'b1, "R10");
        do_load(32'h0000_1048, 20'h00155, 0, 0, 1'b1, "R10");
        do_load(32'h0000_2040, 20'h00155, 0, 0, 1'b0, "R10");
        do_load(32'h0001_0040, 20'h00155, 0, 0, 1'b1, "R10");
        sel = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_and_hit();
        t_physical_tag();
        t_stall();
        t_round_robin();
        t_wide_assoc();
        t_big_page();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule